// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is one channel of a 16-bit timer that produces a repeating rectangular wave. An up-counter runs from zero to a programmed period value and then wraps to zero. The output pin is held active from the wrap point until the counter passes a second programmed value, the width. The counter only steps on clock cycles where the count enable is high. This lets an external prescaler set the count rate without a second clock domain.

Software loads the period and width values through a small write port. A width write goes into a holding register. That value moves into the compare path only when the counter wraps, or while the channel is stopped, so a cycle that is already running is never cut short. The channel runs only when the two-bit mode field selects clear-on-period-match operation and the output enable is high. Each of the two compares raises its own single-cycle interrupt strobe.

Top module: `pulse_gen_timer`

## Requirements
- R1: After synchronous reset, pulse_out, irq_period and irq_width are low, and the counter, period, held width and active width are all zero.
- R2: The channel runs only while mode equals 2'b11 and out_en is high. Otherwise, from the next clock on, the counter sits at zero, pulse_out is low and neither interrupt fires.
- R3: On an enabled count in which the counter equals the period value P, the counter returns to zero. irq_period is high for exactly the following clock, so one wave cycle lasts P+1 enabled counts.
- R4: On an enabled count in which the counter equals the active width W, irq_width is high for exactly the following clock.
- R5: While running, pulse_out is high exactly while the counter value is at most W. The wave is therefore active for W+1 of every P+1 counts.
- R6: When W is greater than or equal to P, pulse_out stays high for the whole cycle.
- R7: A width write goes into a held register. The active width takes the held value at a period match, or on any clock while the channel is stopped, and never at any other time.
- R8: A period write takes effect at the next clock and is used by the next compare.
- R9: A clock with cnt_en low leaves the counter and pulse_out unchanged and raises no interrupt.
- R10: wr_sel selects the target of a write: 0 writes the period, 1 writes the width. Nothing changes while wr_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable, one count per high cycle |
| mode | input | 2 | Operating mode, 2'b11 selects pulse generation |
| out_en | input | 1 | Output enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 period, 1 width |
| wr_data | input | 16 | Write data |
| pulse_out | output | 1 | Pulse output, active high |
| irq_period | output | 1 | Period match strobe |
| irq_width | output | 1 | Width match strobe |

## Verification
All three outputs are registered, so every result that a clock's inputs cause appears one clock later, after the same rising edge that updates the counter. The driver applies inputs on the falling edge. It computes what the outputs must be after the next rising edge and queues that item. The monitor takes one item per rising edge and compares it shortly after that edge, so each check lines up with the one-clock latency. A width write changes the wave no earlier than the wrap that follows it, and the queued expectations carry that delay explicitly.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam logic [1:0] MODE_CLEAR_ON_PERIOD = 2'b11;
  typedef enum logic { SEL_PERIOD = 1'b0, SEL_WIDTH = 1'b1 } wr_target_e;
endpackage

// File: rtl/ppg_cmp_regs.sv
module ppg_cmp_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] period_q,
  output logic [W-1:0] wid_act,
  output logic [W-1:0] wid_next
);
  import ppg_pkg::*;

  logic [W-1:0] hold_q, hold_d;
  logic         wr_period, wr_width;

  assign wr_period = wr_en && (wr_target_e'(wr_sel) == SEL_PERIOD);
  assign wr_width  = wr_en && (wr_target_e'(wr_sel) == SEL_WIDTH);
  assign hold_d    = wr_width ? wr_data : hold_q;
  assign wid_next  = load ? hold_d : wid_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      hold_q   <= '0;
      wid_act  <= '0;
    end else begin
      if (wr_period) period_q <= wr_data;
      hold_q  <= hold_d;
      wid_act <= wid_next;
    end
  end
endmodule

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         cnt_en,
  input  logic [W-1:0] period_q,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d,
  output logic         match_p
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assign match_p = run && cnt_en && (cnt_q == period_q);

  always_comb begin
    if (!run)         cnt_d = '0;
    else if (!cnt_en) cnt_d = cnt_q;
    else if (match_p) cnt_d = '0;
    else              cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ppg_outctl.sv
module ppg_outctl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         cnt_en,
  input  logic         match_p,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] cnt_d,
  input  logic [W-1:0] wid_act,
  input  logic [W-1:0] wid_next,
  output logic         pulse_out,
  output logic         irq_period,
  output logic         irq_width
);
  logic match_w;
  assign match_w = run && cnt_en && (cnt_q == wid_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_out  <= 1'b0;
      irq_period <= 1'b0;
      irq_width  <= 1'b0;
    end else begin
      pulse_out  <= run && (cnt_d <= wid_next);
      irq_period <= match_p;
      irq_width  <= match_w;
    end
  end
endmodule

// File: rtl/pulse_gen_timer.sv
module pulse_gen_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic [1:0]   mode,
  input  logic         out_en,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         pulse_out,
  output logic         irq_period,
  output logic         irq_width
);
  import ppg_pkg::*;

  logic         run, match_p, load;
  logic [W-1:0] period_q, wid_act, wid_next, cnt_q, cnt_d;

  assign run  = (mode == MODE_CLEAR_ON_PERIOD) && out_en;
  assign load = !run || match_p;

  ppg_cmp_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .load(load), .period_q(period_q), .wid_act(wid_act), .wid_next(wid_next)
  );

  ppg_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .cnt_en(cnt_en), .period_q(period_q),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .match_p(match_p)
  );

  ppg_outctl #(.W(W)) u_out (
    .clk(clk), .rst(rst), .run(run), .cnt_en(cnt_en), .match_p(match_p),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .wid_act(wid_act), .wid_next(wid_next),
    .pulse_out(pulse_out), .irq_period(irq_period), .irq_width(irq_width)
  );
endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic [1:0]   mode,
  input logic         out_en,
  input logic         pulse_out,
  input logic         irq_period,
  input logic         irq_width,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] wid_act
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !(mode == 2'b11 && out_en) |=> (!pulse_out && !irq_period && !irq_width && cnt_q == '0));

  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (rst)
    irq_period |-> cnt_q == '0);

  p_width_hit_r4: assert property (@(posedge clk) disable iff (rst)
    irq_width |-> $past(cnt_q) == $past(wid_act));

  p_active_window_r5: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> cnt_q <= wid_act);

  p_hold_no_irq_r9: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> (!irq_period && !irq_width));
endmodule

bind pulse_gen_timer ppg_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode(mode), .out_en(out_en),
  .pulse_out(pulse_out), .irq_period(irq_period), .irq_width(irq_width),
  .cnt_q(cnt_q), .wid_act(wid_act)
);

// File: tb/pulse_gen_timer_test.sv
`timescale 1ns/1ps
module pulse_gen_timer_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         out_en = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         pulse_out, irq_period, irq_width;

  always #2.5 clk = ~clk;

  pulse_gen_timer #(.W(W)) uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode(mode), .out_en(out_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pulse_out(pulse_out), .irq_period(irq_period), .irq_width(irq_width)
  );

  typedef struct {
    logic  out;
    logic  ip;
    logic  iw;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expectation state derived from the requirements
  logic [W-1:0] m_cnt = '0, m_per = '0, m_hold = '0, m_wact = '0;

  task automatic step(input logic ce, input logic [1:0] md, input logic oe,
                      input logic we, input logic sel, input logic [W-1:0] d,
                      input string tag);
    logic run, mp, mw;
    logic [W-1:0] ncnt;
    exp_t e;
    cnt_en = ce; mode = md; out_en = oe; wr_en = we; wr_sel = sel; wr_data = d;
    run = (md == 2'b11) && oe;
    mp  = run && ce && (m_cnt == m_per);
    mw  = run && ce && (m_cnt == m_wact);
    if (!run)    ncnt = '0;
    else if (!ce) ncnt = m_cnt;
    else if (mp) ncnt = '0;
    else         ncnt = m_cnt + 1'b1;
    if (we && sel == 1'b1) m_hold = d;
    if (!run || mp) m_wact = m_hold;
    if (we && sel == 1'b0) m_per = d;
    m_cnt = ncnt;
    e.out = run && (m_cnt <= m_wact);
    e.ip = mp;
    e.iw = mw;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run_n(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 2'b11, 1'b1, 1'b0, 1'b0, '0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pulse_out !== e.out || irq_period !== e.ip || irq_width !== e.iw) begin
        errors++;
        $display("FAIL %s: out/ip/iw got %b%b%b expected %b%b%b at %0t",
                 e.tag, pulse_out, irq_period, irq_width, e.out, e.ip, e.iw, $time);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state observed at the ports
    checks++;
    if (pulse_out !== 1'b0 || irq_period !== 1'b0 || irq_width !== 1'b0) begin
      errors++;
      $display("FAIL R1: got %b%b%b expected 000", pulse_out, irq_period, irq_width);
    end
    // R1: registers zero -> running with P=0,W=0 gives full duty, irq each count
    run_n(3, "R1");
    step(1'b1, 2'b00, 1'b1, 1'b0, 1'b0, '0, "R2");
    // R10: programming while stopped; wr_en low with data has no effect
    step(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 16'd5, "R10");
    step(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 16'd1, "R10");
    step(1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 16'd9, "R10");
    // R2: wrong mode, and output disabled, keep quiet
    for (int i = 0; i < 4; i++) step(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, '0, "R2");
    for (int i = 0; i < 4; i++) step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, '0, "R2");
    // R3 R4 R5: P=5, W=1
    run_n(20, "R3_R4_R5");
    // R9: enable toggling
    for (int i = 0; i < 16; i++) step(i[0] | i[2], 2'b11, 1'b1, 1'b0, 1'b0, '0, "R9");
    for (int i = 0; i < 4; i++) step(1'b0, 2'b11, 1'b1, 1'b0, 1'b0, '0, "R9");
    // R7: width write mid-cycle takes effect only after the wrap
    run_n(2, "R7");
    step(1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 16'd3, "R7");
    run_n(14, "R7");
    // R6: width above and equal to period
    step(1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 16'd7, "R6");
    run_n(14, "R6");
    step(1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 16'd5, "R6");
    run_n(14, "R6");
    // R8: period change used at next compare
    step(1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 16'd0, "R8");
    step(1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 16'd2, "R8");
    run_n(12, "R8");
    step(1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 16'd0, "R8");
    run_n(6, "R8");
    // R2: stop again, then restart
    for (int i = 0; i < 3; i++) step(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, '0, "R2");
    step(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 16'd3, "R2");
    step(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 16'd2, "R2");
    run_n(10, "R2");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule